// File: doc/BRIEF.md
# USB Device Receive Packet FIFO

This block is the write and read logic of the single receive buffer that a device-mode USB controller uses for all OUT and SETUP traffic. Every received packet is stored as one status word followed by its payload in 32-bit words. The status word carries the endpoint, the byte count, the data PID and a packet-status code. A packet engine announces each packet with its length. It streams the payload words and closes the packet with an end strobe that says whether the packet was good. Only good packets become visible to the reader. A bad packet is dropped and leaves no trace in the buffer.

Part of the buffer is held back for traffic that must never be refused. Ten words are kept for SETUP packets on the control endpoint and one word is kept for a global OUT NAK entry. Ordinary OUT packets and transfer-complete entries may not use these words. The block also writes status-only entries, with no payload, for global OUT NAK and for transfer completion. On the read side, software pops one status word, learns the byte count from it, and then pops the payload words. A flag tells software when the word at the head is a status word.

Top module: `usb_rx_pktfifo`

## Requirements
- R1: After reset the buffer is empty, `rd_nonempty` and `rd_stat_vld` are low, and no status-only entry is pending.
- R2: An accepted good packet appears at the read side as one status word followed by its payload words in arrival order. The status word layout is: bits [3:0] endpoint, [14:4] byte count, [16:15] data PID, [20:17] code, all other bits zero. The code is 2 for OUT data and 6 for SETUP data.
- R3: A non-SETUP packet of L bytes is accepted (`pkt_acc` high in the start cycle) only if the free words are at least ceil(L/4)+1+11. Otherwise `pkt_nak` is high in that cycle and nothing is written.
- R4: A SETUP packet of L bytes may use the SETUP reserve. It is accepted if the free words are at least ceil(L/4)+2, so only the global NAK word stays untouched.
- R5: A packet ended with `pkt_err` high is discarded entirely. So is a packet whose payload word count differs from ceil(L/4).
- R6: No word of a packet in progress is visible at the read side before its end strobe commits it.
- R7: A `gnak_req` pulse leads to a status-only entry with code 1, endpoint 0 and byte count 0. The entry needs only one free word. When it is pending together with a transfer-complete entry, it is written first.
- R8: An `xfer_req` pulse leads to a status-only entry with code 3 (OUT complete) or 4 (SETUP complete, `xfer_setup` high), carrying `xfer_ep`. The entry waits until at least 12 words are free. While it waits, further `xfer_req` pulses are dropped.
- R9: `rd_stat_vld` is high exactly when the buffer is non-empty and the head word is a status word. A `rd_pop` on an empty buffer has no effect.
- R10: A `pkt_start` that arrives while a packet is in progress raises neither `pkt_acc` nor `pkt_nak`, and the packet in progress is unaffected.
- R11: With the default 64-word depth, two 64-byte packets are accepted back to back into an empty buffer while the reserve stays intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_start | input | 1 | First cycle of a received packet |
| pkt_setup | input | 1 | Packet is a SETUP packet |
| pkt_ep | input | 4 | Endpoint number of the packet |
| pkt_pid | input | 2 | Data PID of the packet |
| pkt_len | input | 11 | Packet byte count |
| pkt_acc | output | 1 | Packet admitted (start cycle) |
| pkt_nak | output | 1 | Packet refused for lack of space (start cycle) |
| pkt_dvld | input | 1 | Payload word valid |
| pkt_data | input | 32 | Payload word |
| pkt_end | input | 1 | Packet end strobe (carries no data) |
| pkt_err | input | 1 | Packet was bad, qualifies `pkt_end` |
| gnak_req | input | 1 | Request a global OUT NAK entry |
| xfer_req | input | 1 | Request a transfer-complete entry |
| xfer_ep | input | 4 | Endpoint of the completed transfer |
| xfer_setup | input | 1 | Completed transfer was a SETUP stage |
| rd_pop | input | 1 | Remove the head word |
| rd_data | output | 32 | Head word |
| rd_nonempty | output | 1 | At least one committed word present |
| rd_stat_vld | output | 1 | Head word is a status word |

## Verification
The hardest state to reach is the one in which the general space is used up while the SETUP and NAK reserves are still free. Only in that state do the SETUP-only admission rule, the pending transfer-complete entry and the single-word NAK entry differ from ordinary behaviour. The stimulus gets there by writing three maximum-size packets and one small packet with no reads, so that exactly the eleven reserved words remain. It then sends SETUP packets until they are refused, raises both status-only requests, and drains a packet so the held transfer-complete entry drops in behind the NAK entry.

// File: rtl/usb_rxf_pkg.sv
package usb_rxf_pkg;

  localparam int EP_W     = 4;
  localparam int PID_W    = 2;
  localparam int BCNT_W   = 11;
  localparam int BCNT_LSB = EP_W;
  localparam int WORD_W   = 32;

  typedef enum logic [3:0] {
    ST_GNAK       = 4'd1,
    ST_OUT_DATA   = 4'd2,
    ST_OUT_DONE   = 4'd3,
    ST_SETUP_DONE = 4'd4,
    ST_SETUP_DATA = 4'd6
  } rx_stat_e;

  typedef struct packed {
    logic [WORD_W-EP_W-BCNT_W-PID_W-4-1:0] pad;
    rx_stat_e                               code;
    logic [PID_W-1:0]                       pid;
    logic [BCNT_W-1:0]                      bcnt;
    logic [EP_W-1:0]                        ep;
  } rx_stat_t;

endpackage

// File: rtl/usb_rxf_mem.sv
module usb_rxf_mem #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      store[waddr] <= wdata;
    end
  end

  assign rdata = store[raddr];

endmodule

// File: rtl/usb_rxf_admit.sv
module usb_rxf_admit #(
  parameter int DEPTH     = 64,
  parameter int SETUP_RSV = 10,
  parameter int NAK_RSV   = 1,
  parameter int PW        = 7,
  parameter int LW        = 11
) (
  input  logic [PW-1:0] occ,
  input  logic [LW-1:0] len,
  input  logic          is_setup,
  output logic [LW-1:0] need_words,
  output logic          fit_pkt,
  output logic          fit_gnak,
  output logic          fit_xfer
);

  localparam int CW = ((PW > LW) ? PW : LW) + 2;
  localparam logic [CW-1:0] DEP_C   = CW'(DEPTH);
  localparam logic [CW-1:0] NAK_C   = CW'(NAK_RSV);
  localparam logic [CW-1:0] GEN_RSV = CW'(SETUP_RSV + NAK_RSV);

  logic [CW-1:0] free_c;
  logic [CW-1:0] need_c;

  always_comb begin
    free_c     = DEP_C - CW'(occ);
    need_c     = ((CW'(len) + CW'(3)) >> 2) + CW'(1);
    need_words = LW'(need_c);
    fit_gnak   = free_c >= CW'(1);
    fit_xfer   = free_c >= (GEN_RSV + CW'(1));
    if (is_setup) begin
      fit_pkt = free_c >= (need_c + NAK_C);
    end else begin
      fit_pkt = free_c >= (need_c + GEN_RSV);
    end
  end

endmodule

// File: rtl/usb_rxf_rdtrack.sv
module usb_rxf_rdtrack #(
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop_ok,
  input  logic [LW-1:0] head_bcnt,
  output logic          at_status
);

  logic [LW-1:0] rem_q, rem_d;

  always_comb begin
    rem_d = rem_q;
    if (pop_ok) begin
      if (rem_q == '0) begin
        rem_d = LW'((LW'(head_bcnt) + LW'(3)) >> 2);
      end else begin
        rem_d = rem_q - LW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (pop_ok) begin
      rem_q <= rem_d;
    end
  end

  assign at_status = (rem_q == '0);

endmodule

// File: rtl/usb_rx_pktfifo.sv
module usb_rx_pktfifo
  import usb_rxf_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int SETUP_RSV = 10,
  parameter int NAK_RSV   = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pkt_start,
  input  logic                 pkt_setup,
  input  logic [EP_W-1:0]      pkt_ep,
  input  logic [PID_W-1:0]     pkt_pid,
  input  logic [BCNT_W-1:0]    pkt_len,
  output logic                 pkt_acc,
  output logic                 pkt_nak,
  input  logic                 pkt_dvld,
  input  logic [WORD_W-1:0]    pkt_data,
  input  logic                 pkt_end,
  input  logic                 pkt_err,
  input  logic                 gnak_req,
  input  logic                 xfer_req,
  input  logic [EP_W-1:0]      xfer_ep,
  input  logic                 xfer_setup,
  input  logic                 rd_pop,
  output logic [WORD_W-1:0]    rd_data,
  output logic                 rd_nonempty,
  output logic                 rd_stat_vld
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int LW = BCNT_W;

  // pointer and packet state
  logic [PW-1:0] wr_ptr, wr_d, cm_ptr, cm_d, rd_ptr, rd_d, base_ptr, base_d;
  logic          busy, busy_d, cur_setup, setup_d, bad, bad_d;
  logic [LW-1:0] exp_cnt, exp_d, got_cnt, got_d;
  logic          gnak_pend, gnak_d, xfer_pend, xfer_d, xset_q, xset_d;
  logic [EP_W-1:0] xep_q, xep_d;

  // combinational helpers
  logic [PW-1:0] occ_cm;
  logic [LW-1:0] need_words;
  logic          fit_pkt, fit_gnak, fit_xfer;
  logic          start_ok, ins_slot, ins_gnak, ins_xfer, take_word, pop_ok, at_status;
  logic          mem_we;
  logic [WORD_W-1:0] mem_wd;
  rx_stat_t      stat_w;

  assign occ_cm      = cm_ptr - rd_ptr;
  assign rd_nonempty = (cm_ptr != rd_ptr);
  assign pop_ok      = rd_pop && rd_nonempty;
  assign start_ok    = pkt_start && !busy;
  assign pkt_acc     = start_ok && fit_pkt;
  assign pkt_nak     = start_ok && !fit_pkt;
  assign ins_slot    = !busy && !pkt_start;
  assign ins_gnak    = ins_slot && gnak_pend && fit_gnak;
  assign ins_xfer    = ins_slot && !ins_gnak && xfer_pend && fit_xfer;
  assign take_word   = busy && !pkt_end && pkt_dvld && (got_cnt != exp_cnt);
  assign rd_stat_vld = rd_nonempty && at_status;

  usb_rxf_admit #(
    .DEPTH(DEPTH), .SETUP_RSV(SETUP_RSV), .NAK_RSV(NAK_RSV), .PW(PW), .LW(LW)
  ) u_admit (
    .occ(occ_cm), .len(pkt_len), .is_setup(pkt_setup),
    .need_words(need_words), .fit_pkt(fit_pkt), .fit_gnak(fit_gnak), .fit_xfer(fit_xfer)
  );

  usb_rxf_mem #(.DEPTH(DEPTH), .DW(WORD_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(wr_ptr[AW-1:0]), .wdata(mem_wd),
    .raddr(rd_ptr[AW-1:0]), .rdata(rd_data)
  );

  usb_rxf_rdtrack #(.LW(LW)) u_rdtrack (
    .clk(clk), .rst_n(rst_n), .pop_ok(pop_ok),
    .head_bcnt(rd_data[BCNT_LSB +: BCNT_W]), .at_status(at_status)
  );

  // write-port selection
  always_comb begin
    stat_w = '0;
    mem_we = 1'b0;
    mem_wd = '0;
    if (pkt_acc) begin
      stat_w.ep   = pkt_ep;
      stat_w.bcnt = pkt_len;
      stat_w.pid  = pkt_pid;
      stat_w.code = pkt_setup ? ST_SETUP_DATA : ST_OUT_DATA;
      mem_we      = 1'b1;
      mem_wd      = stat_w;
    end else if (take_word) begin
      mem_we = 1'b1;
      mem_wd = pkt_data;
    end else if (ins_gnak) begin
      stat_w.code = ST_GNAK;
      mem_we      = 1'b1;
      mem_wd      = stat_w;
    end else if (ins_xfer) begin
      stat_w.ep   = xep_q;
      stat_w.code = xset_q ? ST_SETUP_DONE : ST_OUT_DONE;
      mem_we      = 1'b1;
      mem_wd      = stat_w;
    end
  end

  // next state
  always_comb begin
    wr_d    = wr_ptr;
    cm_d    = cm_ptr;
    rd_d    = rd_ptr;
    base_d  = base_ptr;
    busy_d  = busy;
    setup_d = cur_setup;
    bad_d   = bad;
    exp_d   = exp_cnt;
    got_d   = got_cnt;
    gnak_d  = gnak_pend;
    xfer_d  = xfer_pend;
    xep_d   = xep_q;
    xset_d  = xset_q;
    if (pkt_acc) begin
      busy_d  = 1'b1;
      setup_d = pkt_setup;
      base_d  = wr_ptr;
      wr_d    = wr_ptr + PW'(1);
      exp_d   = need_words - LW'(1);
      got_d   = '0;
      bad_d   = 1'b0;
    end else if (busy) begin
      if (pkt_end) begin
        busy_d = 1'b0;
        if (!pkt_err && !bad && (got_cnt == exp_cnt)) begin
          cm_d = wr_ptr;
        end else begin
          wr_d = base_ptr;
        end
      end else if (pkt_dvld) begin
        if (take_word) begin
          wr_d  = wr_ptr + PW'(1);
          got_d = got_cnt + LW'(1);
        end else begin
          bad_d = 1'b1;
        end
      end
    end else if (ins_gnak || ins_xfer) begin
      wr_d = wr_ptr + PW'(1);
      cm_d = cm_ptr + PW'(1);
    end
    if (ins_gnak) gnak_d = 1'b0;
    if (gnak_req) gnak_d = 1'b1;
    if (xfer_req && (!xfer_pend || ins_xfer)) begin
      xfer_d = 1'b1;
      xep_d  = xfer_ep;
      xset_d = xfer_setup;
    end else if (ins_xfer) begin
      xfer_d = 1'b0;
    end
    if (pop_ok) rd_d = rd_ptr + PW'(1);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      cm_ptr    <= '0;
      rd_ptr    <= '0;
      base_ptr  <= '0;
      busy      <= 1'b0;
      cur_setup <= 1'b0;
      bad       <= 1'b0;
      exp_cnt   <= '0;
      got_cnt   <= '0;
      gnak_pend <= 1'b0;
      xfer_pend <= 1'b0;
      xep_q     <= '0;
      xset_q    <= 1'b0;
    end else begin
      wr_ptr    <= wr_d;
      cm_ptr    <= cm_d;
      rd_ptr    <= rd_d;
      base_ptr  <= base_d;
      busy      <= busy_d;
      cur_setup <= setup_d;
      bad       <= bad_d;
      exp_cnt   <= exp_d;
      got_cnt   <= got_d;
      gnak_pend <= gnak_d;
      xfer_pend <= xfer_d;
      xep_q     <= xep_d;
      xset_q    <= xset_d;
    end
  end

  // assertions
  logic [PW-1:0] occ_wr;
  assign occ_wr = wr_ptr - rd_ptr;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ_wr <= PW'(DEPTH)); // R3
  AST_GEN_RESERVE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cur_setup) |-> (occ_wr <= PW'(DEPTH - SETUP_RSV - NAK_RSV))); // R3
  AST_SETUP_RESERVE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur_setup) |-> (occ_wr <= PW'(DEPTH - NAK_RSV))); // R4
  AST_NAK_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_nak |=> $stable(wr_ptr)); // R3
  AST_ROLLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pkt_end && pkt_err) |=> ((wr_ptr == cm_ptr) && $stable(cm_ptr))); // R5
  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && !rd_nonempty) |=> $stable(rd_ptr)); // R9

endmodule

// File: tb/usb_rx_pktfifo_tb.sv
module usb_rx_pktfifo_tb_top;

  localparam int CLK_P = 10;
  localparam int DEPTH = 64;
  localparam int RSV   = 11;

  logic clk, rst_n;
  logic pkt_start, pkt_setup, pkt_dvld, pkt_end, pkt_err;
  logic [3:0] pkt_ep, xfer_ep;
  logic [1:0] pkt_pid;
  logic [10:0] pkt_len;
  logic [31:0] pkt_data, rd_data;
  logic pkt_acc, pkt_nak, gnak_req, xfer_req, xfer_setup, rd_pop, rd_nonempty, rd_stat_vld;

  int n_cmp, n_fail;
  bit acc_s;

  usb_rx_pktfifo dut_i (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_setup(pkt_setup),
    .pkt_ep(pkt_ep), .pkt_pid(pkt_pid), .pkt_len(pkt_len), .pkt_acc(pkt_acc),
    .pkt_nak(pkt_nak), .pkt_dvld(pkt_dvld), .pkt_data(pkt_data), .pkt_end(pkt_end),
    .pkt_err(pkt_err), .gnak_req(gnak_req), .xfer_req(xfer_req), .xfer_ep(xfer_ep),
    .xfer_setup(xfer_setup), .rd_pop(rd_pop), .rd_data(rd_data),
    .rd_nonempty(rd_nonempty), .rd_stat_vld(rd_stat_vld)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // reference model state
  logic [31:0] m_q[$];
  logic [31:0] m_w[$];
  bit m_busy, m_bad, m_gp, m_xp, m_xs;
  int m_exp, m_got, m_rem;
  logic [3:0] m_xep;

  function automatic logic [31:0] mk(int code, int pid, int bc, int ep);
    return {11'd0, 4'(code), 2'(pid), 11'(bc), 4'(ep)};
  endfunction

  function automatic bit fits(bit st, int len, int freew);
    int n = (len + 3) / 4 + 1;
    return st ? (freew >= n + 1) : (freew >= n + RSV);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin : model
    int freew;
    bit pop_do, ins_g, ins_x;
    logic [31:0] hd;
    if (!rst_n) begin
      m_q.delete(); m_w.delete();
      m_busy = 0; m_bad = 0; m_gp = 0; m_xp = 0; m_xs = 0;
      m_exp = 0; m_got = 0; m_rem = 0; m_xep = '0;
    end else begin
      freew  = DEPTH - m_q.size();
      pop_do = rd_pop && (m_q.size() > 0);
      ins_g  = 0;
      ins_x  = 0;
      if (!m_busy && pkt_start) begin
        if (fits(pkt_setup, int'(pkt_len), freew)) begin
          m_busy = 1; m_bad = 0; m_got = 0;
          m_exp = (int'(pkt_len) + 3) / 4;
          m_w.delete();
          m_w.push_back(mk(pkt_setup ? 6 : 2, int'(pkt_pid), int'(pkt_len), int'(pkt_ep)));
        end
      end else if (m_busy) begin
        if (pkt_end) begin
          if (!pkt_err && !m_bad && m_got == m_exp)
            foreach (m_w[i]) m_q.push_back(m_w[i]);
          m_w.delete();
          m_busy = 0;
        end else if (pkt_dvld) begin
          if (m_got < m_exp) begin m_w.push_back(pkt_data); m_got++; end
          else m_bad = 1;
        end
      end else begin
        if (m_gp && freew >= 1) begin ins_g = 1; m_q.push_back(mk(1, 0, 0, 0)); end
        else if (m_xp && freew >= RSV + 1) begin
          ins_x = 1; m_q.push_back(mk(m_xs ? 4 : 3, 0, 0, int'(m_xep)));
        end
      end
      if (ins_g) m_gp = 0;
      if (gnak_req) m_gp = 1;
      if (xfer_req && (!m_xp || ins_x)) begin m_xp = 1; m_xep = xfer_ep; m_xs = xfer_setup; end
      else if (ins_x) m_xp = 0;
      if (pop_do) begin
        hd = m_q.pop_front();
        if (m_rem == 0) m_rem = (int'(hd[14:4]) + 3) / 4;
        else m_rem--;
      end
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    bit e_ne, e_acc;
    if (rst_n) begin
      e_ne  = m_q.size() > 0;
      e_acc = !m_busy && pkt_start && fits(pkt_setup, int'(pkt_len), DEPTH - m_q.size());
      chk("R9 rd_nonempty", 32'(rd_nonempty), 32'(e_ne));
      chk("R9 rd_stat_vld", 32'(rd_stat_vld), 32'(e_ne && m_rem == 0));
      if (e_ne) chk("R2/R7/R8 rd_data", rd_data, m_q[0]);
      chk("R3/R4/R10 pkt_acc", 32'(pkt_acc), 32'(e_acc));
      chk("R3/R4/R10 pkt_nak", 32'(pkt_nak), 32'(!m_busy && pkt_start && !e_acc));
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic send_pkt(bit st, int ep, int pid, int len, int nw, bit err);
    pkt_start = 1; pkt_setup = st; pkt_ep = 4'(ep); pkt_pid = 2'(pid); pkt_len = 11'(len);
    #2 acc_s = pkt_acc;
    @(posedge clk); #1;
    pkt_start = 0;
    for (int i = 0; i < nw; i++) begin
      pkt_dvld = 1; pkt_data = $urandom; step();
    end
    pkt_dvld = 0; pkt_end = 1; pkt_err = err; step();
    pkt_end = 0; pkt_err = 0;
  endtask

  task automatic pop_n(int n);
    for (int i = 0; i < n; i++) begin rd_pop = 1; step(); end
    rd_pop = 0;
  endtask

  initial begin : watchdog
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

  initial begin : stim
    n_cmp = 0; n_fail = 0;
    rst_n = 0; pkt_start = 0; pkt_setup = 0; pkt_ep = 0; pkt_pid = 0; pkt_len = 0;
    pkt_dvld = 0; pkt_data = 0; pkt_end = 0; pkt_err = 0; gnak_req = 0; xfer_req = 0;
    xfer_ep = 0; xfer_setup = 0; rd_pop = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 empty after reset", 32'(rd_nonempty), 0);
    chk("R1 no status after reset", 32'(rd_stat_vld), 0);
    step();

    // R2 / R6: OUT packet, 13 bytes, visibility only after commit
    pkt_start = 1; pkt_setup = 0; pkt_ep = 2; pkt_pid = 1; pkt_len = 13;
    #2 chk("R2 accept OUT", 32'(pkt_acc), 1);
    @(posedge clk); #1; pkt_start = 0;
    for (int i = 0; i < 2; i++) begin pkt_dvld = 1; pkt_data = 32'hA000_0000 + i; step(); end
    pkt_dvld = 0;
    @(negedge clk); chk("R6 hidden mid-packet", 32'(rd_nonempty), 0); step();
    for (int i = 2; i < 4; i++) begin pkt_dvld = 1; pkt_data = 32'hA000_0000 + i; step(); end
    pkt_dvld = 0; pkt_end = 1; step(); pkt_end = 0;
    @(negedge clk);
    chk("R2 status word", rd_data, 32'h0004_80D2);
    chk("R9 status at head", 32'(rd_stat_vld), 1);
    step(); pop_n(1);
    @(negedge clk); chk("R9 payload at head", 32'(rd_stat_vld), 0);
    chk("R2 first payload", rd_data, 32'hA000_0000);
    step(); pop_n(4);

    // R4: SETUP packet
    send_pkt(1, 0, 0, 8, 2, 0);
    chk("R4 accept SETUP", 32'(acc_s), 1);
    @(negedge clk); chk("R2 SETUP status", rd_data, 32'h000C_0080); step();
    pop_n(3);

    // R5: error, short and long packets
    send_pkt(0, 1, 0, 8, 2, 1);
    @(negedge clk); chk("R5 error dropped", 32'(rd_nonempty), 0); step();
    send_pkt(0, 1, 0, 12, 2, 0);
    @(negedge clk); chk("R5 short dropped", 32'(rd_nonempty), 0); step();
    send_pkt(0, 1, 0, 4, 3, 0);
    @(negedge clk); chk("R5 long dropped", 32'(rd_nonempty), 0); step();

    // zero-length packet
    send_pkt(0, 1, 0, 0, 0, 0);
    @(negedge clk); chk("R2 zero length", rd_data, 32'h0004_0001); step();
    pop_n(1);
    @(negedge clk); chk("R9 drained", 32'(rd_nonempty), 0); step();

    // R10: start during a packet
    pkt_start = 1; pkt_setup = 0; pkt_ep = 4; pkt_pid = 0; pkt_len = 4; step();
    pkt_len = 0; pkt_dvld = 1; pkt_data = 32'h1234_5678;
    #2 chk("R10 no acc", 32'(pkt_acc), 0); chk("R10 no nak", 32'(pkt_nak), 0);
    @(posedge clk); #1; pkt_start = 0; pkt_dvld = 0; pkt_end = 1; step(); pkt_end = 0;
    @(negedge clk); chk("R10 packet kept", rd_data, 32'h0004_0044); step();
    pop_n(2);

    // R11 / R3 / R4: fill the general space, then the SETUP reserve
    send_pkt(0, 1, 0, 64, 16, 0); chk("R11 first max", 32'(acc_s), 1);
    send_pkt(0, 1, 1, 64, 16, 0); chk("R11 second max", 32'(acc_s), 1);
    send_pkt(0, 2, 0, 64, 16, 0); chk("R3 third max", 32'(acc_s), 1);
    send_pkt(0, 2, 0, 64, 16, 0); chk("R3 fourth nak", 32'(acc_s), 0);
    send_pkt(0, 3, 0, 4, 1, 0);   chk("R3 exact fit", 32'(acc_s), 1);
    send_pkt(0, 3, 0, 0, 0, 0);   chk("R3 reserve kept", 32'(acc_s), 0);
    for (int k = 0; k < 3; k++) begin
      send_pkt(1, 0, 0, 8, 2, 0); chk("R4 SETUP into reserve", 32'(acc_s), 1);
    end
    send_pkt(1, 0, 0, 8, 2, 0); chk("R4 SETUP nak", 32'(acc_s), 0);
    gnak_req = 1; step(); gnak_req = 0; step();
    xfer_req = 1; xfer_ep = 5; xfer_setup = 0; step(); xfer_req = 0;
    step();
    xfer_req = 1; xfer_ep = 7; step(); xfer_req = 0;
    repeat (3) step();
    pop_n(17);
    repeat (2) step();
    pop_n(45);
    @(negedge clk); chk("R7 NAK entry", rd_data, 32'h0002_0000); step();
    pop_n(1);
    @(negedge clk); chk("R8 held entry", rd_data, 32'h0006_0005); step();
    pop_n(1);
    @(negedge clk); chk("R8 duplicate dropped", 32'(rd_nonempty), 0); step();

    // R7 priority over R8 when both pending
    gnak_req = 1; xfer_req = 1; xfer_ep = 3; xfer_setup = 1; step();
    gnak_req = 0; xfer_req = 0;
    repeat (3) step();
    @(negedge clk); chk("R7 NAK first", rd_data, 32'h0002_0000); step();
    pop_n(1);
    @(negedge clk); chk("R8 SETUP complete", rd_data, 32'h0008_0003); step();
    pop_n(1);
    pop_n(2);
    @(negedge clk); chk("R9 pop on empty", 32'(rd_nonempty), 0); step();

    repeat (3) step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

endmodule